// File: doc/BRIEF.md
# Polarity-Selectable Phase/Frequency Comparator

This block compares a divided reference pulse train with a divided feedback pulse train inside one clock domain and produces the drive for an external charge pump. Two internal flops record which train has produced a rising edge in the current comparison cycle. While exactly one of them is set, the charge-pump drive is enabled and its level tells the loop which way to steer. When both are set, or neither, the drive is released to high impedance, modelled here by an output-enable pin. A pair of indicator pins reports the same error direction for a digital observer.

A polarity input flips the sense of every comparator output, so the block suits loops whose oscillator tunes either way. The polarity is latched only when both flops are clear, so a comparison cycle never mixes the two senses. A shared status pin either echoes one of the divided inputs (the reference under high polarity, the feedback under low) or reports lock. Lock means a run of consecutive comparison cycles whose one-sided interval stayed short.

All pins are plain level or pulse signals. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure. Every input is sampled on every clock.

Top module: `pfd_polsel`

## Requirements
- R1: The first clock edge that samples `ref_in` high after a low sets the up flop. The same holds for `fb_in` and the down flop. The comparator outputs reflect the new state right after that edge.
- R2: On the clock edge after both flops are set, both clear. A rising edge sampled on that clearing edge is not recorded.
- R3: With latched polarity high, the drive level is 1 while only the up flop is set and 0 while only the down flop is set. `cp_oe` is 1 in both cases.
- R4: `cp_oe` is 0 whenever both flops are set or both are clear.
- R5: With latched polarity low, the drive levels of R3 are mirrored: 0 while only the up flop is set and 1 while only the down flop is set.
- R6: When the drive is enabled with level 1, `ref_ind` = 1, `fb_ind_oe` = 1 and `fb_ind` = 0. At all other times `ref_ind` = 0 and `fb_ind_oe` = 0.
- R7: With `mon_sel` = 1, `ld_mon` follows `ref_in` combinationally when the latched polarity is 1, and follows `fb_in` when it is 0.
- R8: With `mon_sel` = 0, `ld_mon` = 1 once LOCK_CNT consecutive comparison cycles have each had a one-sided interval of at most PW_MAX clocks. Each cycle is counted on its clearing edge.
- R9: A one-sided interval longer than PW_MAX clocks zeroes the lock count, so `ld_mon` = 0 in lock mode, and the count restarts from the next cycle.
- R10: `pol_sel` is latched only on a clock edge where both flops are clear. A change during an active interval leaves that interval's drive level unchanged.
- R11: After reset both flops are clear, `cp_oe` = 0, `ref_ind` = 0, `fb_ind_oe` = 0, the latched polarity is 1 and the lock count is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Divided reference pulse train |
| fb_in | input | 1 | Divided feedback pulse train |
| pol_sel | input | 1 | Requested comparator polarity |
| mon_sel | input | 1 | 1: status pin echoes an input; 0: lock indication |
| cp_drv | output | 1 | Charge-pump drive level |
| cp_oe | output | 1 | Charge-pump drive enable (0 = high impedance) |
| ref_ind | output | 1 | Direction indicator, always driven |
| fb_ind | output | 1 | Direction indicator level (low when driven) |
| fb_ind_oe | output | 1 | Enable for `fb_ind` |
| ld_mon | output | 1 | Monitor echo or lock indication |

## Verification
The comparator is swept over feedback-to-reference offsets from four clocks behind to four clocks ahead, under both polarities, with every output checked on every cycle. The sweep separates leading from lagging, the zero-offset case where the drive must stay released, and mirrored polarity. A polarity change inside an active interval shows whether latching waits for the cycle boundary. Lock mode is driven with runs of aligned pairs, intervals at exactly PW_MAX, and one-sided intervals just over the limit on each side, which separates the counting, the saturation and the reset of the lock count.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_LEAD = 2'd1,
    ERR_LAG  = 2'd2
  } err_dir_e;
endpackage

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic fb_in,
  output logic up,
  output logic dn
);
  localparam int NCH = 2;
  logic [NCH-1:0] pin_s, pin_q, rise, flop;

  assign pin_s = {fb_in, ref_in};

  for (genvar i = 0; i < NCH; i++) begin : g_edge
    assign rise[i] = pin_s[i] & ~pin_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q <= '0;
      flop  <= '0;
    end else begin
      pin_q <= pin_s;
      for (int i = 0; i < NCH; i++)
        flop[i] <= (&flop) ? 1'b0 : (flop[i] | rise[i]);
    end
  end

  assign up = flop[0];
  assign dn = flop[1];

  p_set_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rise[0] && !(up && dn)) |=> up);
  p_set_dn_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rise[1] && !(up && dn)) |=> dn);
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (up && dn) |=> (!up && !dn));
endmodule

// File: rtl/pfd_drive.sv
module pfd_drive
  import pfd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic up,
  input  logic dn,
  input  logic pol_req,
  output logic pol_q,
  output logic cp_drv,
  output logic cp_oe,
  output logic ref_ind,
  output logic fb_ind,
  output logic fb_ind_oe
);
  err_dir_e dir;

  // polarity latched only between comparison cycles
  always_ff @(posedge clk) begin
    if (!rst_n) pol_q <= 1'b1;
    else if (!up && !dn) pol_q <= pol_req;
  end

  always_comb begin
    dir = ERR_NONE;
    if (up && !dn)      dir = pol_q ? ERR_LEAD : ERR_LAG;
    else if (dn && !up) dir = pol_q ? ERR_LAG : ERR_LEAD;
  end

  assign cp_oe     = (dir != ERR_NONE);
  assign cp_drv    = (dir == ERR_LEAD);
  assign ref_ind   = (dir == ERR_LEAD);
  assign fb_ind_oe = (dir == ERR_LEAD);
  assign fb_ind    = 1'b0;

  p_hiz_equal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (up == dn) |-> !cp_oe);
  p_pol_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (up || dn) |=> $stable(pol_q));
  p_ind_drv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fb_ind_oe |-> (cp_oe && cp_drv && ref_ind && !fb_ind));
endmodule

// File: rtl/pfd_lock.sv
module pfd_lock #(
  parameter int PW_MAX   = 2,
  parameter int LOCK_CNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up,
  input  logic dn,
  output logic locked
);
  localparam int WID_W = (PW_MAX < 1) ? 1 : $clog2(PW_MAX + 1);
  localparam int CNT_W = $clog2(LOCK_CNT + 1);
  localparam logic [WID_W-1:0] WMAX = WID_W'(PW_MAX);
  localparam logic [CNT_W-1:0] CMAX = CNT_W'(LOCK_CNT);

  logic             one_side, bnd, bad;
  logic [WID_W-1:0] wid;
  logic [CNT_W-1:0] cnt;

  assign one_side = up ^ dn;
  assign bnd      = up & dn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wid <= '0;
      bad <= 1'b0;
      cnt <= '0;
    end else if (bnd) begin
      wid <= '0;
      bad <= 1'b0;
      if (bad)              cnt <= '0;
      else if (cnt != CMAX) cnt <= cnt + 1'b1;
    end else if (one_side) begin
      if (wid == WMAX) begin
        bad <= 1'b1;
        cnt <= '0;
      end else begin
        wid <= wid + 1'b1;
      end
    end
  end

  assign locked = (cnt == CMAX);

  p_cnt_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CMAX);
  p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (one_side && wid == WMAX) |=> !locked);
endmodule

// File: rtl/pfd_polsel.sv
module pfd_polsel #(
  parameter int PW_MAX   = 2,
  parameter int LOCK_CNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic fb_in,
  input  logic pol_sel,
  input  logic mon_sel,
  output logic cp_drv,
  output logic cp_oe,
  output logic ref_ind,
  output logic fb_ind,
  output logic fb_ind_oe,
  output logic ld_mon
);
  logic up, dn, pol_q, locked;

  pfd_core u_core (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .up(up), .dn(dn)
  );

  pfd_drive u_drive (
    .clk(clk), .rst_n(rst_n), .up(up), .dn(dn), .pol_req(pol_sel),
    .pol_q(pol_q), .cp_drv(cp_drv), .cp_oe(cp_oe), .ref_ind(ref_ind),
    .fb_ind(fb_ind), .fb_ind_oe(fb_ind_oe)
  );

  pfd_lock #(.PW_MAX(PW_MAX), .LOCK_CNT(LOCK_CNT)) u_lock (
    .clk(clk), .rst_n(rst_n), .up(up), .dn(dn), .locked(locked)
  );

  assign ld_mon = mon_sel ? (pol_q ? ref_in : fb_in) : locked;

  p_oe_bnd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (up && dn) |=> !cp_oe);
  p_mon_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_sel && pol_q) |-> (ld_mon == ref_in));
endmodule

// File: tb/pfd_polsel_test.sv
module pfd_polsel_test;
  localparam int PW_MAX   = 2;
  localparam int LOCK_CNT = 4;

  logic clk = 1'b0;
  logic rst_n, ref_in, fb_in, pol_sel, mon_sel;
  logic cp_drv, cp_oe, ref_ind, fb_ind, fb_ind_oe, ld_mon;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pfd_polsel #(.PW_MAX(PW_MAX), .LOCK_CNT(LOCK_CNT)) uut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .pol_sel(pol_sel), .mon_sel(mon_sel), .cp_drv(cp_drv), .cp_oe(cp_oe),
    .ref_ind(ref_ind), .fb_ind(fb_ind), .fb_ind_oe(fb_ind_oe), .ld_mon(ld_mon)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ref_in = 1'b0;
      fb_in  = 1'b0;
    end
  endtask

  // ref pulse at step a, feedback pulse at step a+d; outputs sampled each step
  task automatic run_pair(input int d, input logic epol, input int chg_t,
                          input logic npol);
    int a = 6;
    int b = 6 + d;
    int m = (d > 0) ? 6 + d : 6;
    logic up_e, dn_e, lead;
    string tag;
    for (int t = 0; t <= m + 4; t++) begin
      @(negedge clk);
      up_e = (t - 1 >= a) && (t - 1 <= m);
      dn_e = (t - 1 >= b) && (t - 1 <= m);
      lead = epol ? (up_e && !dn_e) : (dn_e && !up_e);
      if (t - 1 == a || t - 1 == b) tag = "R1";
      else if (t - 1 == m + 1)      tag = "R2";
      else                          tag = "R4";
      chk(tag, cp_oe, up_e ^ dn_e);
      if (up_e ^ dn_e) chk(epol ? "R3" : "R5", cp_drv, lead);
      chk("R6", ref_ind, lead);
      chk("R6", fb_ind_oe, lead);
      if (fb_ind_oe) chk("R6", fb_ind, 0);
      if (mon_sel && chg_t < 0) chk("R7", ld_mon, epol ? ref_in : fb_in);
      ref_in = (t == a);
      fb_in  = (t == b);
      if (t == chg_t) pol_sel = npol;
    end
  endtask

  task automatic set_pol(input logic p);
    @(negedge clk);
    pol_sel = p;
    idle(2);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ref_in = 1'b0; fb_in = 1'b0; pol_sel = 1'b0; mon_sel = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", cp_oe, 0);
    chk("R11", ref_ind, 0);
    chk("R11", fb_ind_oe, 0);
    chk("R11", ld_mon, 0);
    mon_sel = 1'b1;
    #1 chk("R11", ld_mon, ref_in);  // latched polarity high: echoes ref_in
    mon_sel = 1'b0;
    rst_n = 1'b1;

    // sweep offsets under both polarities, monitor mode on
    mon_sel = 1'b1;
    for (int p = 0; p < 2; p++) begin
      set_pol(p[0]);
      for (int d = -4; d <= 4; d++) begin
        run_pair(d, p[0], -1, 1'b0);
        idle(2);
      end
    end

    // R7 direct echo checks under each polarity
    for (int p = 0; p < 2; p++) begin
      set_pol(p[0]);
      @(negedge clk); ref_in = 1'b1; fb_in = 1'b0;
      #1 chk("R7", ld_mon, p[0] ? 1 : 0);
      @(negedge clk); ref_in = 1'b0; fb_in = 1'b1;
      #1 chk("R7", ld_mon, p[0] ? 0 : 1);
      idle(3);
    end

    // R10 polarity change inside an active interval
    set_pol(1'b1);
    run_pair(4, 1'b1, 8, 1'b0);
    idle(2);
    run_pair(3, 1'b0, -1, 1'b0);  // new polarity now in force
    idle(2);

    // lock detection
    mon_sel = 1'b0;
    set_pol(1'b1);
    run_pair(PW_MAX + 3, 1'b1, -1, 1'b0);
    idle(2);
    chk("R9", ld_mon, 0);
    for (int k = 1; k <= LOCK_CNT; k++) begin
      run_pair(0, 1'b1, -1, 1'b0);
      idle(1);
      chk("R8", ld_mon, (k == LOCK_CNT) ? 1 : 0);
    end
    run_pair(0, 1'b1, -1, 1'b0);
    chk("R8", ld_mon, 1);  // saturated
    run_pair(PW_MAX, 1'b1, -1, 1'b0);
    chk("R8", ld_mon, 1);
    run_pair(-PW_MAX, 1'b1, -1, 1'b0);
    chk("R8", ld_mon, 1);
    run_pair(PW_MAX + 1, 1'b1, -1, 1'b0);
    chk("R9", ld_mon, 0);
    for (int k = 0; k < LOCK_CNT; k++) run_pair(0, 1'b1, -1, 1'b0);
    chk("R8", ld_mon, 1);
    run_pair(-(PW_MAX + 1), 1'b1, -1, 1'b0);
    chk("R9", ld_mon, 0);
    run_pair(0, 1'b1, -1, 1'b0);
    chk("R9", ld_mon, 0);  // count restarted at one

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule